// File: doc/BRIEF.md
# Exception Vector Fetch Sequencer

This block carries a processor with a 16-bit data bus from the moment an exception is raised to the moment its handler's first instruction address is loaded. When it accepts a request, it latches the current status word and program counter. It then issues a status update that forces supervisor mode. Next it forms the vector address and reads the handler address from memory as a pair of 16-bit words. After that it asks the stack side to push the old program counter and status. Finally it loads the new program counter.

The vector address is the 8-bit vector number times four, added to a software-writable base register and cut to the width of the external address bus. A start-up (reset) entry differs from the others in four ways: it always uses vector zero, it reads four words from program space instead of two from data space, it skips the context push, and it delivers an initial stack pointer together with the program counter. A request arriving while a sequence is running is dropped. Instruction decode, the stack memory itself and the choice between competing exception sources belong to neighbouring blocks.

Top module: `exc_vec_seq`

## Requirements
- R1: After synchronous reset the block is idle: busy_o, mem_req_o, push_req_o, sr_load_o, pc_load_o and ssp_load_o are all 0, and the base register holds zero.
- R2: A request (req_i=1) seen at a clock edge while idle is accepted, and busy_o is 1 from the next cycle. A request seen while busy_o=1 is ignored and changes neither addresses nor loaded values.
- R3: The first busy cycle pulses sr_load_o for exactly one cycle. In that cycle sr_new_o equals the status latched at acceptance with bit 13 (supervisor) forced to 1 and bit 15 (trace) forced to 0.
- R4: Word i of a vector is read at byte address (base + vector*4) mod 2^ADDR_W + 2*i. mem_addr_o carries byte-address bits ADDR_W-1 down to 1.
- R5: mem_req_o stays asserted with an unchanged address and space until mem_ack_i is 1 at a clock edge. Exactly one word is taken per acknowledge.
- R6: A normal entry reads two words with mem_prog_o=0 (data space). The word at the lower address is the high half of the new program counter.
- R7: A reset entry (req_reset_i=1) ignores vec_num_i, clears the base register, and reads four words from address 0 with mem_prog_o=1. The first long word goes to ssp_new_o and the second to pc_new_o. No push is requested, and ssp_load_o pulses together with pc_load_o.
- R8: After the last word of a normal entry, push_req_o stays high with push_pc_o and push_sr_o equal to the program counter and status latched at acceptance, until push_ack_i is 1 at a clock edge.
- R9: pc_load_o pulses for one cycle after the fetch (reset) or the push handshake (normal). busy_o is 0 in the following cycle.
- R10: vbr_wr_i=1 writes vbr_wdata_i into the base register. The base is sampled at acceptance, so a write made during a sequence only affects later entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Exception entry request |
| req_reset_i | input | 1 | Request is a start-up entry (vector 0, four words) |
| vec_num_i | input | 8 | Vector number |
| sr_i | input | 16 | Current status word |
| pc_i | input | 32 | Current program counter |
| vbr_wr_i | input | 1 | Base register write enable |
| vbr_wdata_i | input | 32 | Base register write value |
| busy_o | output | 1 | Sequence in progress |
| sr_load_o | output | 1 | Status update strobe |
| sr_new_o | output | 16 | Status for exception mode |
| mem_req_o | output | 1 | Memory word read request |
| mem_addr_o | output | ADDR_W-1 | Word address, byte bits ADDR_W-1..1 |
| mem_prog_o | output | 1 | 1 = supervisor program space, 0 = supervisor data space |
| mem_ack_i | input | 1 | Memory word acknowledge |
| mem_rdata_i | input | 16 | Memory read word |
| push_req_o | output | 1 | Context push request |
| push_pc_o | output | 32 | Program counter to push |
| push_sr_o | output | 16 | Status to push |
| push_ack_i | input | 1 | Context push acknowledge |
| pc_load_o | output | 1 | New program counter strobe |
| pc_new_o | output | 32 | Handler address |
| ssp_load_o | output | 1 | Initial stack pointer strobe |
| ssp_new_o | output | 32 | Initial supervisor stack pointer |

## Verification
The bench builds the block with ADDR_W=20 instead of the default 24. This puts the wrap of base plus offset within reach of a small base value just below 2^20, so the truncation of R4 is exercised without a huge base. The memory and push acknowledge latencies change from entry to entry. This exercises both zero-wait and multi-cycle holding of requests. Extra requests and base writes are injected mid-sequence to show they are ignored or deferred.

// File: rtl/exv_pkg.sv
package exv_pkg;

    localparam int WORD_W       = 16;
    localparam int VEC_W        = 8;
    localparam int SR_SUPV_BIT  = 13;
    localparam int SR_TRACE_BIT = 15;
    localparam int NORMAL_WORDS = 2;
    localparam int START_WORDS  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRSET,
        ST_FETCH,
        ST_PUSH,
        ST_LOAD
    } exv_state_e;

    typedef struct packed {
        logic              is_start;
        logic [WORD_W-1:0] sr;
        logic [31:0]       pc;
    } exv_ctx_t;

    function automatic logic [31:0] vec_offset(input logic [VEC_W-1:0] v);
        return {{(32-VEC_W-2){1'b0}}, v, 2'b00};
    endfunction

    function automatic logic [WORD_W-1:0] sr_for_exception(input logic [WORD_W-1:0] s);
        logic [WORD_W-1:0] r;
        r = s;
        r[SR_SUPV_BIT]  = 1'b1;
        r[SR_TRACE_BIT] = 1'b0;
        return r;
    endfunction

    function automatic logic [1:0] last_word_idx(input logic is_start);
        return is_start ? 2'(START_WORDS - 1) : 2'(NORMAL_WORDS - 1);
    endfunction

endpackage

// File: rtl/exv_addr_gen.sv
module exv_addr_gen
    import exv_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vbr_wr,
    input  logic [31:0]       vbr_wdata,
    input  logic              capture,
    input  logic              cap_start,
    input  logic [VEC_W-1:0]  vec_num,
    input  logic [1:0]        word_idx,
    output logic [ADDR_W-2:0] word_addr
);
    localparam int WA_W = ADDR_W - 1;

    logic [31:0]     vbr_q;
    logic [31:0]     base_q;
    logic [31:0]     sum_w;
    logic [WA_W-1:0] idx_ext;
    logic            unused_bits;

    assign sum_w = vbr_q + vec_offset(vec_num);

    always_ff @(posedge clk) begin
        if (rst) begin
            vbr_q  <= '0;
            base_q <= '0;
        end else begin
            if (capture) begin
                base_q <= cap_start ? 32'd0 : sum_w;
            end
            if (capture && cap_start) begin
                vbr_q <= '0;
            end else if (vbr_wr) begin
                vbr_q <= vbr_wdata;
            end
        end
    end

    assign idx_ext     = {{(WA_W-2){1'b0}}, word_idx};
    assign word_addr   = base_q[ADDR_W-1:1] + idx_ext;
    assign unused_bits = ^{base_q[31:ADDR_W], base_q[0]};

endmodule

// File: rtl/exv_word_col.sv
module exv_word_col
    import exv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take,
    input  logic [WORD_W-1:0] rdata,
    output logic [1:0]        word_idx,
    output logic [31:0]       first_long,
    output logic [31:0]       last_long
);
    logic [4*WORD_W-1:0] shreg_q;
    logic [1:0]          idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            idx_q   <= '0;
        end else if (clear) begin
            idx_q <= '0;
        end else if (take) begin
            shreg_q <= {shreg_q[3*WORD_W-1:0], rdata};
            idx_q   <= idx_q + 2'd1;
        end
    end

    assign word_idx   = idx_q;
    assign first_long = shreg_q[4*WORD_W-1:2*WORD_W];
    assign last_long  = shreg_q[2*WORD_W-1:0];

endmodule

// File: rtl/exc_vec_seq.sv
module exc_vec_seq
    import exv_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              req_reset_i,
    input  logic [7:0]        vec_num_i,
    input  logic [15:0]       sr_i,
    input  logic [31:0]       pc_i,
    input  logic              vbr_wr_i,
    input  logic [31:0]       vbr_wdata_i,
    output logic              busy_o,
    output logic              sr_load_o,
    output logic [15:0]       sr_new_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:1] mem_addr_o,
    output logic              mem_prog_o,
    input  logic              mem_ack_i,
    input  logic [15:0]       mem_rdata_i,
    output logic              push_req_o,
    output logic [31:0]       push_pc_o,
    output logic [15:0]       push_sr_o,
    input  logic              push_ack_i,
    output logic              pc_load_o,
    output logic [31:0]       pc_new_o,
    output logic              ssp_load_o,
    output logic [31:0]       ssp_new_o
);
    exv_state_e        state_q, state_d;
    exv_ctx_t          ctx_q;
    logic              accept;
    logic              take;
    logic [1:0]        word_idx;
    logic [31:0]       first_long;
    logic [31:0]       last_long;
    logic [ADDR_W-2:0] word_addr;

    assign accept = (state_q == ST_IDLE) && req_i;
    assign take   = (state_q == ST_FETCH) && mem_ack_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_i) state_d = ST_SRSET;
            ST_SRSET: state_d = ST_FETCH;
            ST_FETCH: begin
                if (mem_ack_i && (word_idx == last_word_idx(ctx_q.is_start))) begin
                    state_d = ctx_q.is_start ? ST_LOAD : ST_PUSH;
                end
            end
            ST_PUSH:  if (push_ack_i) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                ctx_q.is_start <= req_reset_i;
                ctx_q.sr       <= sr_i;
                ctx_q.pc       <= pc_i;
            end
        end
    end

    exv_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .vbr_wr    (vbr_wr_i),
        .vbr_wdata (vbr_wdata_i),
        .capture   (accept),
        .cap_start (req_reset_i),
        .vec_num   (vec_num_i),
        .word_idx  (word_idx),
        .word_addr (word_addr)
    );

    exv_word_col u_col (
        .clk        (clk),
        .rst        (rst),
        .clear      (state_q == ST_SRSET),
        .take       (take),
        .rdata      (mem_rdata_i),
        .word_idx   (word_idx),
        .first_long (first_long),
        .last_long  (last_long)
    );

    assign busy_o     = (state_q != ST_IDLE);
    assign sr_load_o  = (state_q == ST_SRSET);
    assign sr_new_o   = sr_for_exception(ctx_q.sr);
    assign mem_req_o  = (state_q == ST_FETCH);
    assign mem_addr_o = word_addr;
    assign mem_prog_o = ctx_q.is_start;
    assign push_req_o = (state_q == ST_PUSH);
    assign push_pc_o  = ctx_q.pc;
    assign push_sr_o  = ctx_q.sr;
    assign pc_load_o  = (state_q == ST_LOAD);
    assign pc_new_o   = last_long;
    assign ssp_load_o = (state_q == ST_LOAD) && ctx_q.is_start;
    assign ssp_new_o  = first_long;

endmodule

// File: rtl/exv_checker.sv
module exv_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              req_i,
    input logic              busy_o,
    input logic              sr_load_o,
    input logic [15:0]       sr_new_o,
    input logic              mem_req_o,
    input logic [ADDR_W-1:1] mem_addr_o,
    input logic              mem_prog_o,
    input logic              mem_ack_i,
    input logic              push_req_o,
    input logic [31:0]       push_pc_o,
    input logic [15:0]       push_sr_o,
    input logic              push_ack_i,
    input logic              pc_load_o,
    input logic              ssp_load_o
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !(mem_req_o || push_req_o || sr_load_o || pc_load_o || ssp_load_o));

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && req_i) |=> (busy_o && sr_load_o));

    p_sr_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        sr_load_o |=> !sr_load_o);

    p_sr_mode_r3: assert property (@(posedge clk) disable iff (rst)
        sr_load_o |-> (sr_new_o[13] && !sr_new_o[15]));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_ack_i) |=> (!mem_req_o || (mem_addr_o == $past(mem_addr_o) + 1'b1)));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_prog_o)));

    p_ssp_with_pc_r7: assert property (@(posedge clk) disable iff (rst)
        ssp_load_o |-> pc_load_o);

    p_push_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (push_req_o && !push_ack_i) |=> (push_req_o && $stable(push_pc_o) && $stable(push_sr_o)));

    p_load_end_r9: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |=> !busy_o);

endmodule

bind exc_vec_seq exv_checker #(.ADDR_W(ADDR_W)) u_exv_checker (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .busy_o     (busy_o),
    .sr_load_o  (sr_load_o),
    .sr_new_o   (sr_new_o),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_prog_o (mem_prog_o),
    .mem_ack_i  (mem_ack_i),
    .push_req_o (push_req_o),
    .push_pc_o  (push_pc_o),
    .push_sr_o  (push_sr_o),
    .push_ack_i (push_ack_i),
    .pc_load_o  (pc_load_o),
    .ssp_load_o (ssp_load_o)
);

// File: tb/test_exc_vec_seq.sv
module test_exc_vec_seq;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_i = 1'b0, req_reset_i = 1'b0;
    logic [7:0]    vec_num_i = '0;
    logic [15:0]   sr_i = '0;
    logic [31:0]   pc_i = '0;
    logic          vbr_wr_i = 1'b0;
    logic [31:0]   vbr_wdata_i = '0;
    logic          busy_o, sr_load_o, mem_req_o, mem_prog_o, push_req_o, pc_load_o, ssp_load_o;
    logic [15:0]   sr_new_o, push_sr_o;
    logic [AW-1:1] mem_addr_o;
    logic          mem_ack_i = 1'b0;
    logic [15:0]   mem_rdata_i = '0;
    logic [31:0]   push_pc_o, pc_new_o, ssp_new_o;
    logic          push_ack_i = 1'b0;

    int nchk = 0, nerr = 0;
    int mlat = 0, plat = 0, mcnt = 0, pcnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    exc_vec_seq #(.ADDR_W(AW)) i_exc_vec_seq (
        .clk(clk), .rst(rst), .req_i(req_i), .req_reset_i(req_reset_i),
        .vec_num_i(vec_num_i), .sr_i(sr_i), .pc_i(pc_i),
        .vbr_wr_i(vbr_wr_i), .vbr_wdata_i(vbr_wdata_i),
        .busy_o(busy_o), .sr_load_o(sr_load_o), .sr_new_o(sr_new_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_prog_o(mem_prog_o),
        .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .push_req_o(push_req_o), .push_pc_o(push_pc_o), .push_sr_o(push_sr_o),
        .push_ack_i(push_ack_i), .pc_load_o(pc_load_o), .pc_new_o(pc_new_o),
        .ssp_load_o(ssp_load_o), .ssp_new_o(ssp_new_o)
    );

    function automatic logic [15:0] memw(input logic [AW-2:0] a, input logic p);
        return {a[7:0] ^ 8'h96, p, a[14:8]};
    endfunction

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // memory and push responders
    always @(negedge clk) begin
        if (mem_req_o && !mem_ack_i) begin
            if (mcnt >= mlat) begin
                mem_ack_i   <= 1'b1;
                mem_rdata_i <= memw(mem_addr_o, mem_prog_o);
                mcnt = 0;
            end else mcnt++;
        end else mem_ack_i <= 1'b0;
        if (push_req_o && !push_ack_i) begin
            if (pcnt >= plat) begin
                push_ack_i <= 1'b1;
                pcnt = 0;
            end else pcnt++;
        end else push_ack_i <= 1'b0;
    end

    // behavioural reference model
    int          ph = 0;
    int          widx = 0;
    logic        m_start = 0;
    logic [15:0] m_sr = '0;
    logic [31:0] m_pc = '0, m_vbr = '0, m_base = '0;
    logic [15:0] w [4];

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; m_vbr = '0;
        end else begin
            case (ph)
                0: if (req_i) begin
                    ph = 1; m_start = req_reset_i; m_sr = sr_i; m_pc = pc_i;
                    m_base = req_reset_i ? 32'd0
                           : ((m_vbr + 32'(vec_num_i) * 4) & ((32'd1 << AW) - 1));
                    if (req_reset_i) m_vbr = '0;
                end
                1: begin ph = 2; widx = 0; end
                2: if (mem_ack_i) begin
                    w[widx] = mem_rdata_i;
                    widx++;
                    if (widx == (m_start ? 4 : 2)) ph = m_start ? 4 : 3;
                end
                3: if (push_ack_i) ph = 4;
                default: ph = 0;
            endcase
            if (vbr_wr_i && !(ph == 1 && m_start && $past(req_i))) m_vbr = vbr_wdata_i;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            int n;
            n = m_start ? 4 : 2;
            check("R2 busy", 64'(busy_o), 64'(ph != 0));
            check("R3 sr_load", 64'(sr_load_o), 64'(ph == 1));
            if (ph == 1) check("R3 sr_new", 64'(sr_new_o), 64'((m_sr | 16'h2000) & 16'h7FFF));
            check("R5 mem_req", 64'(mem_req_o), 64'(ph == 2));
            if (ph == 2) begin
                check("R4 addr", 64'(mem_addr_o), 64'(((m_base >> 1) + 32'(widx)) & ((32'd1 << (AW-1)) - 1)));
                check(m_start ? "R7 space" : "R6 space", 64'(mem_prog_o), 64'(m_start));
            end
            check("R8 push_req", 64'(push_req_o), 64'(ph == 3));
            if (ph == 3) begin
                check("R8 push_pc", 64'(push_pc_o), 64'(m_pc));
                check("R8 push_sr", 64'(push_sr_o), 64'(m_sr));
            end
            check("R9 pc_load", 64'(pc_load_o), 64'(ph == 4));
            check("R7 ssp_load", 64'(ssp_load_o), 64'(ph == 4 && m_start));
            if (ph == 4) begin
                check(m_start ? "R7 pc_new" : "R6 pc_new", 64'(pc_new_o), 64'({w[n-2], w[n-1]}));
                if (m_start) check("R7 ssp_new", 64'(ssp_new_o), 64'({w[0], w[1]}));
            end
        end
    end

    task automatic entry(input logic st, input logic [7:0] v, input logic [15:0] s,
                         input logic [31:0] p, input int ml, input int pl);
        @(negedge clk);
        mlat = ml; plat = pl;
        req_i = 1'b1; req_reset_i = st; vec_num_i = v; sr_i = s; pc_i = p;
        @(negedge clk);
        req_i = 1'b0; req_reset_i = 1'b0;
        for (int k = 0; k < 200 && busy_o; k++) @(negedge clk);
    endtask

    task automatic wr_base(input logic [31:0] d);
        @(negedge clk); vbr_wr_i = 1'b1; vbr_wdata_i = d;
        @(negedge clk); vbr_wr_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 64'(busy_o), 64'd0);
        check("R1 mem_req", 64'(mem_req_o), 64'd0);
        check("R1 push_req", 64'(push_req_o), 64'd0);
        check("R1 loads", 64'({sr_load_o, pc_load_o, ssp_load_o}), 64'd0);
        rst = 1'b0;
        // R1: base zero, first normal entry from vector 0x19 at byte 0x64
        entry(1'b0, 8'h19, 16'h0704, 32'h0001_2344, 0, 0);
        // R7 start-up entry, vector number ignored
        entry(1'b1, 8'h55, 16'h8000, 32'hDEAD_BEEE, 2, 0);
        // R5/R8 slow handshakes
        entry(1'b0, 8'h02, 16'hA71F, 32'h00FE_DCBA, 3, 4);
        // R10 base write, then a write and an extra request mid-flight
        wr_base(32'h0000_1000);
        @(negedge clk);
        mlat = 4; plat = 1;
        req_i = 1'b1; vec_num_i = 8'h40; sr_i = 16'h2300; pc_i = 32'h0000_4000;
        @(negedge clk);
        vec_num_i = 8'h7F; vbr_wr_i = 1'b1; vbr_wdata_i = 32'h0000_2000; // R2 ignored, R10 deferred
        @(negedge clk);
        req_i = 1'b0; vbr_wr_i = 1'b0;
        check("R10 addr", 64'(mem_addr_o), 64'((32'h1000 + 32'h100) >> 1));
        for (int k = 0; k < 200 && busy_o; k++) @(negedge clk);
        entry(1'b0, 8'h03, 16'h0000, 32'h0000_0010, 1, 1); // R10 new base 0x2000
        // R4 wrap past 2^AW
        wr_base(32'h000F_FFF0);
        entry(1'b0, 8'hFF, 16'hFFFF, 32'h1234_5678, 0, 2);
        // R7 start-up clears base; following entry uses base 0
        entry(1'b1, 8'h00, 16'h0000, 32'h0, 0, 0);
        entry(1'b0, 8'h05, 16'h1111, 32'h0000_0222, 0, 0);
        @(negedge clk);
        check("R9 idle after load", 64'(busy_o), 64'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule